// File: doc/BRIEF.md
# Serial Audio Port Control Register Bank

This block is the software-visible register bank of a stereo serial audio port. A host reaches it over a simple single-cycle bus carrying valid, write, byte address and 32-bit data. Sixteen word registers sit at a 4-byte stride from offset 0x00 to 0x3C. Each address has its own access rule. Plain configuration words are readable and writable. The transmit FIFO port can only be written. The receive FIFO port, the FIFO status and the interrupt status can only be read, and they show live values supplied by the datapath. The two sample counters are updated by hardware, and software can load them.

The bank decodes its configuration words into the fields that the FIFO and the serial shifter consume. These are the enables, the clock mode, the data-line enables, the alignment modes and the DMA request enables. It also exports the full format, clock divider and channel words. Writing the transmit FIFO address, reading the receive FIFO address, or writing a flush bit each produces a one-cycle strobe toward the FIFO. The FIFO storage itself lives outside the block.

Top module: `audio_port_regs`

## Requirements
- R1: After synchronous reset every register reads zero, except these: 0x04 = 0x0000000C, 0x08 = 0x00004020, 0x14 = 0x000400F0, 0x30 = 0x1, 0x34 = 0x76543210, 0x38 = 0x1 and 0x3C = 0x00003210. All strobes are low after reset.
- R2: The control word at 0x00 drives the control outputs. port_en is bit 0, rx_en is bit 1, tx_en is bit 2, slave_mode is bit 5 (1 = clock follower, 0 = clock source) and line_en[3:0] is bits 11:8.
- R3: Address 0x0C is write-only and a read of it returns zero. A write to it pulses tx_fifo_wr for exactly the following cycle, with tx_fifo_wdata equal to the written word.
- R4: Addresses 0x10, 0x18 and 0x20 are read-only. A read of them returns rx_fifo_data, fifo_status and irq_status respectively, as sampled at the request edge. Writes to them change nothing. A read of 0x10 pulses rx_fifo_rd in the following cycle.
- R5: In the FIFO control word at 0x14, a write with bit 25 set pulses tx_flush for one cycle, and a write with bit 24 set pulses rx_flush for one cycle, both in the cycle after the write. Bits 25:24 always read back zero. tx_align is bit 2 and rx_align is bits 1:0.
- R6: In the DMA word at 0x1C, bit 7 drives tx_dreq_en and bit 3 drives rx_dreq_en.
- R7: The RX count at 0x28 and the TX count at 0x2C each increase by one for every cycle in which rx_sample_inc or tx_sample_inc is high. Each wraps from 0xFFFFFFFF to zero. A write loads the written value.
- R8: A bus write to a count register in the same cycle as its increment input loads the written value, and the increment is dropped.
- R9: Read data appears on bus_rdata in the cycle after the request. bus_rdata is zero in every cycle that does not follow a read.
- R10: Addresses at or above 0x40 read zero, and writes to them change no register and raise no strobe.
- R11: The words at 0x04, 0x08, 0x24, 0x30, 0x34, 0x38 and 0x3C store all 32 written bits. They read back as written and appear on the matching word outputs in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, low two bits ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_fifo_data | input | DATA_W | Head word of the receive FIFO |
| fifo_status | input | DATA_W | Live FIFO status word |
| irq_status | input | DATA_W | Live interrupt status word |
| tx_sample_inc | input | 1 | Transmit sample done, increments TX count |
| rx_sample_inc | input | 1 | Receive sample done, increments RX count |
| tx_fifo_wr | output | 1 | Push strobe to transmit FIFO |
| tx_fifo_wdata | output | DATA_W | Word pushed to transmit FIFO |
| rx_fifo_rd | output | 1 | Pop strobe to receive FIFO |
| tx_flush | output | 1 | Transmit FIFO flush pulse |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| port_en | output | 1 | Whole-port enable |
| rx_en | output | 1 | Receive path enable |
| tx_en | output | 1 | Transmit path enable |
| slave_mode | output | 1 | 1 = bit and frame clocks are inputs |
| line_en | output | LINES | Serial data output line enables |
| tx_align | output | 1 | Transmit sample alignment mode |
| rx_align | output | 2 | Receive sample alignment mode |
| tx_dreq_en | output | 1 | Transmit DMA request enable |
| rx_dreq_en | output | 1 | Receive DMA request enable |
| fmt0_word | output | DATA_W | Format word 0 |
| fmt1_word | output | DATA_W | Format word 1 |
| clkdiv_word | output | DATA_W | Clock divider word |
| tx_chan_sel | output | DATA_W | Transmit channel select word |
| tx_chan_map | output | DATA_W | Transmit channel map word |
| rx_chan_sel | output | DATA_W | Receive channel select word |
| rx_chan_map | output | DATA_W | Receive channel map word |

## Verification
The assertions check four things on every cycle. Every flush and FIFO strobe must trace back to the matching bus request one cycle earlier. Idle cycles and transmit FIFO reads must return zero. A counter write must win over a same-cycle increment. An increment alone must add exactly one. The reset values, the full per-address access map, counter wrap, and the proof that writes to read-only or unmapped addresses leave every register untouched come from the bench. It compares a behavioural model against every output on every clock across directed sequences, a mid-run reset and thousands of random requests.

// File: rtl/apr_pkg.sv
package apr_pkg;
  localparam int NUM_REGS = 16;
  localparam int WORD_W   = 32;

  // Word indices (byte offset / 4)
  localparam int IDX_CTRL   = 0;
  localparam int IDX_FMT0   = 1;
  localparam int IDX_FMT1   = 2;
  localparam int IDX_TXFIFO = 3;
  localparam int IDX_RXFIFO = 4;
  localparam int IDX_FCTL   = 5;
  localparam int IDX_FSTAT  = 6;
  localparam int IDX_DMA    = 7;
  localparam int IDX_ISTAT  = 8;
  localparam int IDX_CDIV   = 9;
  localparam int IDX_RXCNT  = 10;
  localparam int IDX_TXCNT  = 11;
  localparam int IDX_TXSEL  = 12;
  localparam int IDX_TXMAP  = 13;
  localparam int IDX_RXSEL  = 14;
  localparam int IDX_RXMAP  = 15;

  // Field positions decoded by the datapath
  localparam int CTRL_PORT_BIT  = 0;
  localparam int CTRL_RX_BIT    = 1;
  localparam int CTRL_TX_BIT    = 2;
  localparam int CTRL_MODE_BIT  = 5;
  localparam int CTRL_LINE_LSB  = 8;
  localparam int FCTL_TXFL_BIT  = 25;
  localparam int FCTL_RXFL_BIT  = 24;
  localparam int FCTL_TXAL_BIT  = 2;
  localparam int FCTL_RXAL_LSB  = 0;
  localparam int DMA_TXDRQ_BIT  = 7;
  localparam int DMA_RXDRQ_BIT  = 3;

  // Plain configuration storage lives at these indices
  function automatic bit is_stored(int idx);
    case (idx)
      IDX_CTRL, IDX_FMT0, IDX_FMT1, IDX_FCTL, IDX_DMA, IDX_CDIV,
      IDX_TXSEL, IDX_TXMAP, IDX_RXSEL, IDX_RXMAP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] reset_word(int idx);
    case (idx)
      IDX_FMT0:  return 32'h0000_000C;
      IDX_FMT1:  return 32'h0000_4020;
      IDX_FCTL:  return 32'h0004_00F0;
      IDX_TXSEL: return 32'h0000_0001;
      IDX_TXMAP: return 32'h7654_3210;
      IDX_RXSEL: return 32'h0000_0001;
      IDX_RXMAP: return 32'h0000_3210;
      default:   return '0;
    endcase
  endfunction

  // Bits that are kept on write; the flush bits are pulses only
  function automatic logic [WORD_W-1:0] keep_bits(int idx);
    logic [WORD_W-1:0] m;
    m = '1;
    if (idx == IDX_FCTL) begin
      m[FCTL_TXFL_BIT] = 1'b0;
      m[FCTL_RXFL_BIT] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/apr_addr_decode.sv
module apr_addr_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic                rd_any
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  assign word_idx = bus_addr[ADDR_W-1:2];
  assign rd_any   = bus_valid && !bus_write;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    logic hit;
    assign hit       = (word_idx == IDX_W'(i));
    assign wr_sel[i] = bus_valid &&  bus_write && hit;
    assign rd_sel[i] = bus_valid && !bus_write && hit;
  end
endmodule

// File: rtl/apr_cfg_reg.sv
module apr_cfg_reg #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    RST  = '0,
  parameter logic [W-1:0]    KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST;
    else if (wr_en) q <= wdata & KEEP;
  end
endmodule

// File: rtl/apr_sample_counter.sv
module apr_sample_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (wr_en) cnt <= wdata;
    else if (inc)   cnt <= cnt + W'(1);
  end

  // R8
  wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt == $past(wdata));

  // R7
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && inc) |=> cnt == $past(cnt) + W'(1));
endmodule

// File: rtl/audio_port_regs.sv
module audio_port_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] rx_fifo_data,
  input  logic [DATA_W-1:0] fifo_status,
  input  logic [DATA_W-1:0] irq_status,
  input  logic              tx_sample_inc,
  input  logic              rx_sample_inc,
  output logic              tx_fifo_wr,
  output logic [DATA_W-1:0] tx_fifo_wdata,
  output logic              rx_fifo_rd,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic              port_en,
  output logic              rx_en,
  output logic              tx_en,
  output logic              slave_mode,
  output logic [LINES-1:0]  line_en,
  output logic              tx_align,
  output logic [1:0]        rx_align,
  output logic              tx_dreq_en,
  output logic              rx_dreq_en,
  output logic [DATA_W-1:0] fmt0_word,
  output logic [DATA_W-1:0] fmt1_word,
  output logic [DATA_W-1:0] clkdiv_word,
  output logic [DATA_W-1:0] tx_chan_sel,
  output logic [DATA_W-1:0] tx_chan_map,
  output logic [DATA_W-1:0] rx_chan_sel,
  output logic [DATA_W-1:0] rx_chan_map
);
  import apr_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [NUM_REGS-1:0] wr_sel, rd_sel;
  logic                rd_any;
  logic [DATA_W-1:0]   store_q  [NUM_REGS];
  logic [DATA_W-1:0]   read_src [NUM_REGS];
  logic [DATA_W-1:0]   rx_cnt, tx_cnt;
  logic [DATA_W-1:0]   rd_word;

  apr_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .wr_sel    (wr_sel),
    .rd_sel    (rd_sel),
    .rd_any    (rd_any)
  );

  // Configuration storage: one register per stored index
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_store
    if (is_stored(i)) begin : g_cfg
      apr_cfg_reg #(
        .W    (DATA_W),
        .RST  (DATA_W'(reset_word(i))),
        .KEEP (DATA_W'(keep_bits(i)))
      ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_sel[i]),
        .wdata (bus_wdata),
        .q     (store_q[i])
      );
    end else begin : g_none
      assign store_q[i] = '0;
    end
  end

  apr_sample_counter #(.W(DATA_W)) u_rx_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (rx_sample_inc),
    .wr_en (wr_sel[IDX_RXCNT]),
    .wdata (bus_wdata),
    .cnt   (rx_cnt)
  );

  apr_sample_counter #(.W(DATA_W)) u_tx_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (tx_sample_inc),
    .wr_en (wr_sel[IDX_TXCNT]),
    .wdata (bus_wdata),
    .cnt   (tx_cnt)
  );

  // Read sources: storage by default, live values for volatile words
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) read_src[i] = store_q[i];
    read_src[IDX_RXFIFO] = rx_fifo_data;
    read_src[IDX_FSTAT]  = fifo_status;
    read_src[IDX_ISTAT]  = irq_status;
    read_src[IDX_RXCNT]  = rx_cnt;
    read_src[IDX_TXCNT]  = tx_cnt;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_sel[i]) rd_word = read_src[i];
  end

  // Registered read data and strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      tx_fifo_wr <= 1'b0;
      rx_fifo_rd <= 1'b0;
      tx_flush   <= 1'b0;
      rx_flush   <= 1'b0;
    end else begin
      bus_rdata  <= rd_any ? rd_word : '0;
      tx_fifo_wr <= wr_sel[IDX_TXFIFO];
      rx_fifo_rd <= rd_sel[IDX_RXFIFO];
      tx_flush   <= wr_sel[IDX_FCTL] && bus_wdata[FCTL_TXFL_BIT];
      rx_flush   <= wr_sel[IDX_FCTL] && bus_wdata[FCTL_RXFL_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     tx_fifo_wdata <= '0;
    else if (wr_sel[IDX_TXFIFO]) tx_fifo_wdata <= bus_wdata;
  end

  // Decoded fields
  assign port_en     = store_q[IDX_CTRL][CTRL_PORT_BIT];
  assign rx_en       = store_q[IDX_CTRL][CTRL_RX_BIT];
  assign tx_en       = store_q[IDX_CTRL][CTRL_TX_BIT];
  assign slave_mode  = store_q[IDX_CTRL][CTRL_MODE_BIT];
  assign line_en     = store_q[IDX_CTRL][CTRL_LINE_LSB +: LINES];
  assign tx_align    = store_q[IDX_FCTL][FCTL_TXAL_BIT];
  assign rx_align    = store_q[IDX_FCTL][FCTL_RXAL_LSB +: 2];
  assign tx_dreq_en  = store_q[IDX_DMA][DMA_TXDRQ_BIT];
  assign rx_dreq_en  = store_q[IDX_DMA][DMA_RXDRQ_BIT];
  assign fmt0_word   = store_q[IDX_FMT0];
  assign fmt1_word   = store_q[IDX_FMT1];
  assign clkdiv_word = store_q[IDX_CDIV];
  assign tx_chan_sel = store_q[IDX_TXSEL];
  assign tx_chan_map = store_q[IDX_TXMAP];
  assign rx_chan_sel = store_q[IDX_RXSEL];
  assign rx_chan_map = store_q[IDX_RXMAP];

  // Assertions
  logic [IDX_W-1:0] a_idx;
  assign a_idx = bus_addr[ADDR_W-1:2];

  // R5
  tx_flush_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_flush |-> $past(bus_valid && bus_write && a_idx == IDX_W'(IDX_FCTL)
                       && bus_wdata[FCTL_TXFL_BIT]));

  // R5
  rx_flush_src_chk: assert property (@(posedge clk) disable iff (rst)
    rx_flush |-> $past(bus_valid && bus_write && a_idx == IDX_W'(IDX_FCTL)
                       && bus_wdata[FCTL_RXFL_BIT]));

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> bus_rdata == '0);

  // R3
  txfifo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && a_idx == IDX_W'(IDX_TXFIFO)) |=> bus_rdata == '0);

  // R4
  rx_pop_src_chk: assert property (@(posedge clk) disable iff (rst)
    rx_fifo_rd |-> $past(bus_valid && !bus_write && a_idx == IDX_W'(IDX_RXFIFO)));

  // R3
  tx_push_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_wr |-> $past(bus_valid && bus_write && a_idx == IDX_W'(IDX_TXFIFO)));
endmodule

// File: tb/test_audio_port_regs.sv
module test_audio_port_regs;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] rx_fifo_data = '0, fifo_status = '0, irq_status = '0;
  logic tx_sample_inc = 1'b0, rx_sample_inc = 1'b0;
  logic tx_fifo_wr, rx_fifo_rd, tx_flush, rx_flush;
  logic [DW-1:0] tx_fifo_wdata;
  logic port_en, rx_en, tx_en, slave_mode, tx_align, tx_dreq_en, rx_dreq_en;
  logic [3:0] line_en;
  logic [1:0] rx_align;
  logic [DW-1:0] fmt0_word, fmt1_word, clkdiv_word;
  logic [DW-1:0] tx_chan_sel, tx_chan_map, rx_chan_sel, rx_chan_map;

  audio_port_regs #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) i_audio_port_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_fifo_data(rx_fifo_data), .fifo_status(fifo_status), .irq_status(irq_status),
    .tx_sample_inc(tx_sample_inc), .rx_sample_inc(rx_sample_inc),
    .tx_fifo_wr(tx_fifo_wr), .tx_fifo_wdata(tx_fifo_wdata), .rx_fifo_rd(rx_fifo_rd),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .port_en(port_en), .rx_en(rx_en),
    .tx_en(tx_en), .slave_mode(slave_mode), .line_en(line_en), .tx_align(tx_align),
    .rx_align(rx_align), .tx_dreq_en(tx_dreq_en), .rx_dreq_en(rx_dreq_en),
    .fmt0_word(fmt0_word), .fmt1_word(fmt1_word), .clkdiv_word(clkdiv_word),
    .tx_chan_sel(tx_chan_sel), .tx_chan_map(tx_chan_map),
    .rx_chan_sel(rx_chan_sel), .rx_chan_map(rx_chan_map)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  // Behavioural reference state
  logic [31:0] m_word [int];      // stored words by word index
  logic [31:0] m_rxcnt, m_txcnt;
  string       m_rxtag, m_txtag;
  logic [31:0] e_rdata, e_txwd;
  logic        e_txwr, e_rxrd, e_txfl, e_rxfl;
  string       e_rtag;
  bit          primed = 0;
  bit          fresh  = 1;        // no write since reset

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic void model_reset();
    m_word.delete();
    m_word[0] = 32'h0;          m_word[1] = 32'h0000_000C;
    m_word[2] = 32'h0000_4020;  m_word[5] = 32'h0004_00F0;
    m_word[7] = 32'h0;          m_word[9] = 32'h0;
    m_word[12] = 32'h1;         m_word[13] = 32'h7654_3210;
    m_word[14] = 32'h1;         m_word[15] = 32'h0000_3210;
    m_rxcnt = 0; m_txcnt = 0; m_rxtag = "R7"; m_txtag = "R7";
    e_rdata = 0; e_txwd = 0; e_txwr = 0; e_rxrd = 0; e_txfl = 0; e_rxfl = 0;
    e_rtag = "R1";
    fresh = 1;
  endfunction

  function automatic logic [31:0] model_read(int idx);
    if (idx >= 16) return 0;
    case (idx)
      3:  return 0;
      4:  return rx_fifo_data;
      6:  return fifo_status;
      8:  return irq_status;
      10: return m_rxcnt;
      11: return m_txcnt;
      default: return m_word[idx];
    endcase
  endfunction

  function automatic string read_tag(int idx);
    if (fresh) return "R1";
    if (idx >= 16) return "R10";
    case (idx)
      0: return "R2";
      3: return "R3";
      4, 6, 8: return "R4";
      5: return "R5";
      7: return "R6";
      10: return m_rxtag;
      11: return m_txtag;
      default: return "R11";
    endcase
  endfunction

  task automatic compare_outputs();
    string ft;
    ft = fresh ? "R1" : "R2";
    chk(e_rtag, bus_rdata, e_rdata);
    chk(fresh ? "R1" : "R3", {31'b0, tx_fifo_wr}, {31'b0, e_txwr});
    if (e_txwr) chk("R3", tx_fifo_wdata, e_txwd);
    chk(fresh ? "R1" : "R4", {31'b0, rx_fifo_rd}, {31'b0, e_rxrd});
    chk(fresh ? "R1" : "R5", {31'b0, tx_flush}, {31'b0, e_txfl});
    chk(fresh ? "R1" : "R5", {31'b0, rx_flush}, {31'b0, e_rxfl});
    chk(ft, {24'b0, line_en, slave_mode, rx_en, tx_en, port_en},
        {24'b0, m_word[0][11:8], m_word[0][5], m_word[0][1], m_word[0][2], m_word[0][0]});
    chk(fresh ? "R1" : "R5", {29'b0, tx_align, rx_align}, {29'b0, m_word[5][2], m_word[5][1:0]});
    chk(fresh ? "R1" : "R6", {30'b0, tx_dreq_en, rx_dreq_en}, {30'b0, m_word[7][7], m_word[7][3]});
    ft = fresh ? "R1" : "R11";
    chk(ft, fmt0_word, m_word[1]);
    chk(ft, fmt1_word, m_word[2]);
    chk(ft, clkdiv_word, m_word[9]);
    chk(ft, tx_chan_sel, m_word[12]);
    chk(ft, tx_chan_map, m_word[13]);
    chk(ft, rx_chan_sel, m_word[14]);
    chk(ft, rx_chan_map, m_word[15]);
  endtask

  // One clock of stimulus: compare, drive, advance the model
  task automatic step(bit r, bit v, bit w, int idx, logic [31:0] d, bit ti, bit ri);
    bit rd, wr, tcol, rcol;
    @(negedge clk);
    if (primed) compare_outputs();
    rst = r; bus_valid = v; bus_write = w; bus_addr = AW'(idx * 4); bus_wdata = d;
    tx_sample_inc = ti; rx_sample_inc = ri;
    rx_fifo_data = $urandom; fifo_status = $urandom; irq_status = $urandom;
    if (r) begin
      model_reset();
      primed = 1;
      return;
    end
    rd = v && !w;
    wr = v && w;
    e_rdata = rd ? model_read(idx) : 0;
    e_rtag  = rd ? read_tag(idx) : "R9";
    e_txwr = wr && idx == 3;
    if (e_txwr) e_txwd = d;
    e_rxrd = rd && idx == 4;
    e_txfl = wr && idx == 5 && d[25];
    e_rxfl = wr && idx == 5 && d[24];
    tcol = wr && idx == 11;
    rcol = wr && idx == 10;
    if (tcol) begin m_txcnt = d; m_txtag = ti ? "R8" : "R7"; end
    else if (ti) begin m_txcnt = m_txcnt + 1; m_txtag = "R7"; end
    if (rcol) begin m_rxcnt = d; m_rxtag = ri ? "R8" : "R7"; end
    else if (ri) begin m_rxcnt = m_rxcnt + 1; m_rxtag = "R7"; end
    if (wr && idx < 16 && m_word.exists(idx))
      m_word[idx] = (idx == 5) ? (d & 32'hFCFF_FFFF) : d;
    if (wr) fresh = 0;
  endtask

  task automatic wr_reg(int idx, logic [31:0] d); step(0, 1, 1, idx, d, 0, 0); endtask
  task automatic rd_reg(int idx);                 step(0, 1, 0, idx, 0, 0, 0); endtask
  task automatic idle();                          step(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    model_reset();
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    // R1: read every address, including unmapped ones
    for (int i = 0; i < 20; i++) rd_reg(i);
    idle();
    // R2: control fields
    wr_reg(0, 32'h0000_0A27);
    rd_reg(0);
    wr_reg(0, 32'h0000_0500);
    idle();
    // R5: flush pulses, back to back, and readback of cleared bits
    wr_reg(5, 32'h0300_0007);
    wr_reg(5, 32'h0200_0000);
    rd_reg(5);
    wr_reg(5, 32'h0100_0002);
    idle();
    // R6
    wr_reg(7, 32'h0000_0088);
    rd_reg(7);
    wr_reg(7, 32'h0000_0008);
    // R3: push to transmit FIFO, read returns zero
    wr_reg(3, 32'hDEAD_BEEF);
    rd_reg(3);
    wr_reg(3, 32'h1234_5678);
    idle();
    // R4: read-only addresses, writes ignored
    wr_reg(4, 32'hFFFF_FFFF);
    wr_reg(6, 32'hFFFF_FFFF);
    wr_reg(8, 32'hFFFF_FFFF);
    rd_reg(4); rd_reg(6); rd_reg(8);
    // R10: unmapped writes ignored
    wr_reg(16, 32'hFFFF_FFFF);
    wr_reg(19, 32'hFFFF_FFFF);
    rd_reg(16); rd_reg(0);
    // R7: counter increment and wrap
    wr_reg(11, 32'hFFFF_FFFE);
    step(0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    rd_reg(11);
    step(0, 1, 0, 10, 0, 1, 0);
    rd_reg(10);
    // R8: write beats increment
    step(0, 1, 1, 11, 32'h0000_0000, 1, 0);
    rd_reg(11);
    step(0, 1, 1, 10, 32'h0000_0055, 0, 1);
    rd_reg(10);
    // R11: full-width stored words
    foreach (m_word[k]) if (k != 5) wr_reg(k, 32'hA5A5_0000 | k);
    for (int i = 0; i < 16; i++) rd_reg(i);
    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      int idx;
      logic [31:0] d;
      idx = $urandom_range(0, 19);
      d = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      step(0, $urandom_range(0, 9) < 7, $urandom_range(0, 1), idx, d,
           $urandom_range(0, 1), $urandom_range(0, 1));
      if (n == 1500) begin
        step(1, 1, 1, 0, 32'hFFFF_FFFF, 1, 1);
        for (int i = 0; i < 16; i++) rd_reg(i);
      end
    end
    idle();
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_bad++;
        $display("FAIL R9 watchdog actual=running expected=finished by cycle 200000");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end
endmodule